// File: doc/BRIEF.md
# Three-Channel Filtered Input Capture

This block timestamps edges on external signals against a free-running counter held elsewhere. It has three capture channels. Each one picks its source from a bank of nine input pins and, if asked, cleans that source with a glitch filter. It then watches for a chosen edge type. When a matching edge arrives, the channel stores the counter value it was given into its own 16-bit register and raises a flag that stays up. In that same cycle it pulses a strobe towards the counter.

The counter is not part of the block. Its count arrives as an input. When software sets the clear-on-capture control, the block asks the counter to restart on any capture. The value stored by the capture is the count from before that restart, so the difference between two successive edges can be read directly as a period or a pulse width. The three flags feed a single interrupt line, which is gated by a capture-interrupt enable and a global enable.

All inputs pass through a synchronizer first. Edge detection works on the synchronized and, optionally, filtered level, so the time from a pin change to a capture is fixed and known.

Top module: `cap3_capture_front`

## Requirements
- R1: After reset, all flags, all capture registers, the interrupt, every strobe and the counter clear request read 0.
- R2: A channel's 4-bit select value p routes input pin p, for p from 0 to 8. Select values 9 to 15 give a constant low source that never causes a capture. Edges on pins that are not selected have no effect.
- R3: The 2-bit edge field per channel is encoded as follows: 00 captures falling edges, 01 captures rising edges, 10 captures both edges, and 11 captures nothing.
- R4: With the filter off, a pin change made before clock edge E0 is captured at edge E2. E0 and E1 are the two synchronizer stages, and the edge is detected between E1 and E2. The stored value is the count presented at edge E2.
- R5: With the filter on, a synchronized level is accepted only after it has been held for 4 consecutive clocks. Pulses of 1 to 3 clocks are dropped. An accepted edge is captured 4 clocks later than it would be with the filter off.
- R6: A channel whose enable bit is clear never sets its flag and never changes its capture register. An edge that occurs while the channel is disabled is not remembered once the channel is enabled.
- R7: A flag stays set until its clear bit is pulsed. If a clear and a capture fall in the same cycle, the flag is left set.
- R8: The interrupt is high exactly when at least one flag is set and both the capture-interrupt enable and the global enable are high.
- R9: On a qualifying edge, the channel's strobe is high for one cycle. The counter clear request equals the OR of the strobes gated by the clear-on-capture input. The captured value is the count present in that same strobe cycle, which is the count before the clear.
- R10: When several channels see a qualifying edge in the same cycle, each one sets its own flag and stores the same count.
- R11: A capture register keeps its value until the next qualifying edge on its channel, which overwrites it even while the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 9 | Candidate input pins, asynchronous |
| timer_cnt_i | input | 16 | Shared counter value |
| ch_en_i | input | 3 | Per-channel enable |
| ch_filt_en_i | input | 3 | Per-channel glitch filter enable |
| ch_mode_i | input | 6 | Edge field per channel, channel c in bits 2c+1:2c |
| ch_sel_i | input | 12 | Pin select per channel, channel c in bits 4c+3:4c |
| flag_clr_i | input | 3 | Per-channel flag clear pulse |
| cap_irq_en_i | input | 1 | Capture interrupt enable |
| glb_irq_en_i | input | 1 | Global interrupt enable |
| clr_on_cap_i | input | 1 | Request a counter clear on every capture |
| cap_strobe_o | output | 3 | Per-channel capture strobe |
| timer_clr_o | output | 1 | Counter clear request |
| flag_o | output | 3 | Per-channel sticky capture flag |
| cap_val_o | output | 48 | Capture registers, channel c in bits 16c+15:16c |
| irq_o | output | 1 | Combined capture interrupt |

## Verification
The bench counts up the counter by one in every cycle, so each captured value shows the exact cycle in which the capture happened. It sweeps every channel against all nine pin selects and all three active edge codes. For each combination it drives a rise and then a fall, which separates the edge encodings, the fixed capture latency and overwrite from hold. Before each rise it toggles a neighbouring pin, which shows whether routing is correct.

The filter is tried with pulse widths from one to six clocks, which locates the 3/4-clock boundary. Further patterns cover the following:
- out-of-range selects and the reserved edge code
- an edge that occurs while the channel is disabled
- a clear that coincides with a capture
- three channels firing together
- all four combinations of the interrupt enables

// File: rtl/cap3_pkg.sv
package cap3_pkg;
   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/cap3_condition.sv
// Synchronizer followed by an optional stability filter.
module cap3_condition #(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1,
   parameter int FILT_LEN    = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   input  logic filt_en_i,
   output logic level_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], din_i};
   end
   assign raw = sync_q[SYNC_STAGES-1];

   generate
      if (HAS_FILTER) begin : g_filt
         localparam int CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] run_q;
         logic          filt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               run_q  <= '0;
               filt_q <= 1'b0;
            end else if (raw == filt_q) begin
               run_q  <= '0;
            end else if (run_q == LAST) begin
               run_q  <= '0;
               filt_q <= raw;
            end else begin
               run_q  <= run_q + 1'b1;
            end
         end
         assign level_o = filt_en_i ? filt_q : raw;

         // Shadow counter: the number of consecutive samples the raw level has held.
         localparam logic [CW:0] SAT = (CW+1)'(FILT_LEN);
         logic          chk_last_q;
         logic [CW:0]   chk_same_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chk_last_q <= 1'b0;
               chk_same_q <= '0;
            end else begin
               chk_last_q <= raw;
               if (raw != chk_last_q)    chk_same_q <= (CW+1)'(1);
               else if (chk_same_q != SAT) chk_same_q <= chk_same_q + 1'b1;
            end
         end

         // R5: the filtered level moves only after the raw level has held for FILT_LEN samples
         p_filt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (filt_q != $past(filt_q)) |-> (($past(chk_same_q) >= SAT - 1'b1) && ($past(raw) == filt_q)));
      end else begin : g_nofilt
         assign level_o = raw;
      end
   endgenerate
endmodule

// File: rtl/cap3_edge.sv
// Edge qualifier working on the conditioned level.
module cap3_edge
   import cap3_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       level_i,
   input  logic       en_i,
   input  edge_mode_e mode_i,
   output logic       hit_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= level_i;
   end

   assign rise = level_i & ~prev_q;
   assign fall = ~level_i & prev_q;

   always_comb begin
      unique case (mode_i)
         EDGE_FALL: hit_o = en_i & fall;
         EDGE_RISE: hit_o = en_i & rise;
         EDGE_BOTH: hit_o = en_i & (rise | fall);
         default:   hit_o = 1'b0;
      endcase
   end

   // R3: the reserved code never qualifies an edge
   p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == EDGE_OFF) |-> !hit_o);
   // R6: a disabled channel never qualifies an edge
   p_dis_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> !hit_o);
endmodule

// File: rtl/cap3_channel.sv
// One capture channel: pin select, conditioning, edge qualification, storage.
module cap3_channel
   import cap3_pkg::*;
#(
   parameter int NUM_PINS    = 9,
   parameter int SEL_W       = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1,
   parameter int FILT_LEN    = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  edge_mode_e          mode_i,
   input  logic                filt_en_i,
   input  logic                en_i,
   input  logic                clr_i,
   input  logic [CNT_W-1:0]    cnt_i,
   output logic                hit_o,
   output logic                flag_o,
   output logic [CNT_W-1:0]    cap_o
);
   logic src;
   logic level;

   always_comb begin
      src = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (sel_i == SEL_W'(p)) src = pins_i[p];
      end
   end

   cap3_condition #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_FILTER  (HAS_FILTER),
      .FILT_LEN    (FILT_LEN)
   ) i_cond (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .din_i     (src),
      .filt_en_i (filt_en_i),
      .level_o   (level)
   );

   cap3_edge i_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level),
      .en_i    (en_i),
      .mode_i  (mode_i),
      .hit_o   (hit_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_o <= 1'b0;
         cap_o  <= '0;
      end else begin
         if (hit_o) begin
            flag_o <= 1'b1;
            cap_o  <= cnt_i;
         end else if (clr_i) begin
            flag_o <= 1'b0;
         end
      end
   end

   // R4: a strobe stores the count seen in the strobe cycle
   p_cap_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |=> (cap_o == $past(cnt_i)));
   // R11: without a strobe the stored count is held
   p_cap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_o |=> $stable(cap_o));
   // R7: a flag only drops after a clear request
   p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);
   // R7: a capture always leaves the flag set, even against a clear
   p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |=> flag_o);
endmodule

// File: rtl/cap3_capture_front.sv
// Three-channel capture front end sharing one external counter.
module cap3_capture_front
   import cap3_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int NUM_PINS    = 9,
   parameter int SEL_W       = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1,
   parameter int FILT_LEN    = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_PINS-1:0]       pins_i,
   input  logic [CNT_W-1:0]          timer_cnt_i,
   input  logic [NUM_CH-1:0]         ch_en_i,
   input  logic [NUM_CH-1:0]         ch_filt_en_i,
   input  logic [2*NUM_CH-1:0]       ch_mode_i,
   input  logic [SEL_W*NUM_CH-1:0]   ch_sel_i,
   input  logic [NUM_CH-1:0]         flag_clr_i,
   input  logic                      cap_irq_en_i,
   input  logic                      glb_irq_en_i,
   input  logic                      clr_on_cap_i,
   output logic [NUM_CH-1:0]         cap_strobe_o,
   output logic                      timer_clr_o,
   output logic [NUM_CH-1:0]         flag_o,
   output logic [CNT_W*NUM_CH-1:0]   cap_val_o,
   output logic                      irq_o
);
   generate
      if (NUM_PINS > (1 << SEL_W)) begin : g_bad_sel
         $error("select field too narrow for the pin count");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchronizer stages are needed");
      end
      if (HAS_FILTER && FILT_LEN < 2) begin : g_bad_filt
         $error("filter length must be at least 2");
      end
      if (NUM_CH < 1 || CNT_W < 1) begin : g_bad_size
         $error("channel count and counter width must be positive");
      end
   endgenerate

   logic [NUM_CH-1:0] hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cap3_channel #(
         .NUM_PINS    (NUM_PINS),
         .SEL_W       (SEL_W),
         .CNT_W       (CNT_W),
         .SYNC_STAGES (SYNC_STAGES),
         .HAS_FILTER  (HAS_FILTER),
         .FILT_LEN    (FILT_LEN)
      ) i_chan (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .pins_i    (pins_i),
         .sel_i     (ch_sel_i[SEL_W*c +: SEL_W]),
         .mode_i    (edge_mode_e'(ch_mode_i[2*c +: 2])),
         .filt_en_i (ch_filt_en_i[c]),
         .en_i      (ch_en_i[c]),
         .clr_i     (flag_clr_i[c]),
         .cnt_i     (timer_cnt_i),
         .hit_o     (hit[c]),
         .flag_o    (flag_o[c]),
         .cap_o     (cap_val_o[CNT_W*c +: CNT_W])
      );
   end

   assign cap_strobe_o = hit;
   assign timer_clr_o  = clr_on_cap_i & (|hit);
   assign irq_o        = cap_irq_en_i & glb_irq_en_i & (|flag_o);

   // R9: a clear request is always backed by a capture landing at the next edge
   p_clr_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timer_clr_o |=> (|flag_o));
   // R8: the interrupt never rises without a flag behind it
   p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (|flag_o));
endmodule

// File: tb/test_cap3_capture_front.sv
`timescale 1ns/1ps
module test_cap3_capture_front;
   localparam int NCH = 3;
   localparam int NP  = 9;
   localparam int SW  = 4;
   localparam int CW  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     pins = '0;
   logic [CW-1:0]     tcnt = '0;
   logic [NCH-1:0]    en = '0, fen = '0, fclr = '0;
   logic [2*NCH-1:0]  mode = '0;
   logic [SW*NCH-1:0] sel = '0;
   logic              irq_en = 1'b0, glb_en = 1'b0, cac = 1'b0;
   logic [NCH-1:0]    strobe, flags;
   logic [CW*NCH-1:0] caps;
   logic              irq, tclr;
   int                checks = 0, errors = 0;
   bit                done = 1'b0;

   always #4 clk = ~clk;

   cap3_capture_front i_cap3_capture_front (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .pins_i       (pins),
      .timer_cnt_i  (tcnt),
      .ch_en_i      (en),
      .ch_filt_en_i (fen),
      .ch_mode_i    (mode),
      .ch_sel_i     (sel),
      .flag_clr_i   (fclr),
      .cap_irq_en_i (irq_en),
      .glb_irq_en_i (glb_en),
      .clr_on_cap_i (cac),
      .cap_strobe_o (strobe),
      .timer_clr_o  (tclr),
      .flag_o       (flags),
      .cap_val_o    (caps),
      .irq_o        (irq)
   );

   // One cycle: wait for the falling edge, then advance the counter by one.
   task automatic step(int n);
      repeat (n) begin
         @(negedge clk);
         tcnt = tcnt + 1'b1;
      end
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_flags();
      fclr = '1;
      step(1);
      fclr = '0;
   endtask

   function automatic logic [CW-1:0] cap_of(int c);
      return caps[CW*c +: CW];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] t0, t1, held;
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1: reset state
      chk("R1", "flags", 32'(flags), 0);
      chk("R1", "captures", 32'(caps[31:0]), 0);
      chk("R1", "capture ch2", 32'(cap_of(2)), 0);
      chk("R1", "irq", 32'(irq), 0);
      chk("R1", "strobes", 32'(strobe), 0);
      chk("R1", "timer clear", 32'(tclr), 0);

      // Sweep: channel x pin select x edge code, filter off.
      for (int c = 0; c < NCH; c++) begin
         for (int s = 0; s < NP; s++) begin
            for (int m = 0; m < 3; m++) begin
               bit exp_r, exp_f;
               int other;
               exp_r = (m == 1) || (m == 2);
               exp_f = (m == 0) || (m == 2);
               other = (s + 1) % NP;
               en = '0;
               en[c] = 1'b1;
               fen = '0;
               mode[2*c +: 2] = 2'(m);
               sel[SW*c +: SW] = 4'(s);
               step(2);
               clear_flags();
               pins[other] = 1'b1;
               step(4);
               pins[other] = 1'b0;
               step(4);
               chk("R2", "unselected pin toggled", 32'(flags), 0);
               t0 = tcnt;
               pins[s] = 1'b1;
               step(3);
               chk("R3", "flags after rise", 32'(flags), exp_r ? (32'd1 << c) : 0);
               if (exp_r) chk("R4", "rise capture", 32'(cap_of(c)), 32'(16'(t0 + 16'd2)));
               held = cap_of(c);
               step(2);
               t1 = tcnt;
               pins[s] = 1'b0;
               step(3);
               chk("R3", "flags after fall", 32'(flags), (exp_r || exp_f) ? (32'd1 << c) : 0);
               if (exp_f) chk("R11", "fall overwrites", 32'(cap_of(c)), 32'(16'(t1 + 16'd2)));
               else       chk("R11", "capture held", 32'(cap_of(c)), 32'(held));
               clear_flags();
               chk("R7", "clear drops flags", 32'(flags), 0);
            end
         end
      end

      // R2: select codes 9..15 give a constant low source
      en = 3'b001; mode[1:0] = 2'b10;
      for (int s = 9; s < 16; s++) begin
         sel[3:0] = 4'(s);
         step(2);
         pins = '1;
         step(5);
         pins = '0;
         step(5);
         chk("R2", "out-of-range select", 32'(flags), 0);
      end

      // R3: code 11 captures nothing
      sel[3:0] = 4'd0; mode[1:0] = 2'b11;
      step(2);
      pins[0] = 1'b1; step(5); pins[0] = 1'b0; step(5);
      chk("R3", "reserved edge code", 32'(flags), 0);

      // R6: edge while disabled is not seen, not remembered
      en = '0; mode[1:0] = 2'b01;
      held = cap_of(0);
      step(2);
      pins[0] = 1'b1; step(6);
      chk("R6", "disabled flag", 32'(flags), 0);
      chk("R6", "disabled capture", 32'(cap_of(0)), 32'(held));
      en = 3'b001; step(4);
      chk("R6", "no late edge on enable", 32'(flags), 0);
      pins[0] = 1'b0; step(5);
      chk("R6", "fall ignored in rise mode", 32'(flags), 0);

      // R5: filter pulse-width sweep on channel 1, pin 3, rising edges
      en = 3'b010; fen = 3'b010; mode[3:2] = 2'b01; sel[7:4] = 4'd3;
      step(12);
      for (int w = 1; w <= 6; w++) begin
         clear_flags();
         t0 = tcnt;
         pins[3] = 1'b1;
         step(w);
         pins[3] = 1'b0;
         step(12);
         chk("R5", $sformatf("filter width %0d flag", w), 32'(flags[1]), (w >= 4) ? 1 : 0);
         if (w >= 4) chk("R5", "filtered capture time", 32'(cap_of(1)), 32'(16'(t0 + 16'd6)));
      end

      // R9: strobe and clear request in the cycle of capture
      fen = '0; sel[7:4] = 4'd2; cac = 1'b1;
      step(4);
      clear_flags();
      t0 = tcnt;
      pins[2] = 1'b1;
      step(2);
      chk("R9", "strobe in capture cycle", 32'(strobe), 32'b010);
      chk("R9", "clear request", 32'(tclr), 1);
      step(1);
      chk("R9", "strobe one cycle", 32'(strobe), 0);
      chk("R9", "clear request one cycle", 32'(tclr), 0);
      chk("R9", "pre-clear count kept", 32'(cap_of(1)), 32'(16'(t0 + 16'd2)));
      cac = 1'b0; mode[3:2] = 2'b10;
      step(1);
      pins[2] = 1'b0;
      step(2);
      chk("R9", "strobe without clear", 32'(strobe), 32'b010);
      chk("R9", "no clear when disabled", 32'(tclr), 0);
      step(2);

      // R10: all channels on one pin
      en = 3'b111; mode = 6'b010101; sel = {4'd5, 4'd5, 4'd5};
      step(3);
      clear_flags();
      t0 = tcnt;
      pins[5] = 1'b1;
      step(2);
      chk("R10", "all strobes", 32'(strobe), 32'b111);
      step(1);
      chk("R10", "all flags", 32'(flags), 32'b111);
      for (int c = 0; c < NCH; c++)
         chk("R10", $sformatf("shared count ch%0d", c), 32'(cap_of(c)), 32'(16'(t0 + 16'd2)));
      pins[5] = 1'b0;
      step(4);

      // R7: clear coinciding with a capture leaves the flag set
      en = 3'b100; sel[11:8] = 4'd7;
      step(3);
      clear_flags();
      pins[7] = 1'b1;
      step(2);
      fclr = 3'b100;
      step(1);
      fclr = '0;
      chk("R7", "set beats clear", 32'(flags), 32'b100);
      step(8);
      chk("R7", "flag sticky", 32'(flags), 32'b100);

      // R8: interrupt gating
      for (int a = 0; a < 2; a++) begin
         for (int b = 0; b < 2; b++) begin
            irq_en = 1'(a); glb_en = 1'(b);
            step(1);
            chk("R8", $sformatf("irq en=%0d glb=%0d", a, b), 32'(irq), (a == 1 && b == 1) ? 1 : 0);
         end
      end
      clear_flags();
      chk("R8", "irq after clear", 32'(irq), 0);
      chk("R7", "flag cleared", 32'(flags), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule